// File: doc/BRIEF.md
# Multi-level page table walker

The walker turns a 64-bit virtual address into a real address. It follows a chain of translation tables that live in memory. A 64-bit space descriptor selects the first table. The descriptor carries the table origin, the kind of table the walk starts from (region-first, region-second, region-third or segment), a two-bit length limit, a real-space flag and a private flag. The walker reads one 8-byte table entry per level through a request/response memory port. At every level it checks the entry's invalid, type, length and protection fields. The walk can end early on a large-frame entry at segment or region-third level. When it finishes, the walker reports the real address together with write and execute permission, or it reports an exception code.

The virtual address is cut from the top into four 11-bit indices (region-first at bits 63:53, region-second at 52:42, region-third at 41:31, segment at 30:20), an 8-bit page index at 19:12 and a 12-bit byte offset. A caller pulses `start` while the block is idle. After that it waits for the one-cycle `done` pulse and then reads the held result outputs.

Top module: `pt_walker`

## Requirements
- R1: When descriptor bit 4 (real space) is set, the walk returns `raddr` equal to `vaddr`, `fault_code` 0 and both permissions set, and it makes no memory request.
- R2: Descriptor bits 3:2 set the starting level (3 region-first, 2 region-second, 1 region-third, 0 segment). If any index above the starting level is nonzero, the walk ends with code 3 before any memory read.
- R3: If the top two bits of the starting index exceed descriptor bits 1:0, the walk ends without a read and reports the starting level's translation code (region-first 4, region-second 5, region-third 6, segment 7).
- R4: Each entry is read at the table origin plus index times 8. Region tables are 4 KiB aligned (origin bits 63:12), and page tables are 2 KiB aligned (segment entry bits 63:11). Entries are big-endian, so response byte lane k (bits 8k+7:8k) holds the byte at address+k.
- R5: An entry with bit 5 set reports its own level's translation code (4, 5, 6, 7, or 8 for a page entry).
- R6: A region or segment entry whose bits 3:2 do not equal its level number (3, 2, 1, 0) reports code 2.
- R7: A region entry gives the next index range through bits 7:6 (lower bound) and bits 1:0 (upper bound). If the next index's top two bits fall outside that range, the walk reports the next level's translation code.
- R8: Bit 9 clears `wr_ok`. It always acts on segment and page entries, but on region entries only when `seg_frame_en` is set.
- R9: Bit 10 ends the walk in two cases. On a segment entry it needs `seg_frame_en`, and `raddr` becomes entry bits 63:20 joined with virtual bits 19:0. On a region-third entry it needs both enables, and `raddr` becomes entry bits 63:31 joined with virtual bits 30:0. Without the enables the bit has no effect.
- R10: Code 2 is reported in three cases: bit 4 set on a segment entry while descriptor bit 5 (private) is set; the same on a region-third entry while both enables are set; and bit 11 set on a page entry.
- R11: With `xprot_en` set, bit 8 of a page entry or of a large-frame entry clears `ex_ok`.
- R12: A memory response with `mem_rsp_err` set ends the walk with code 1.
- R13: After reset the block is idle with no request and no `done`. `done` lasts one cycle. A faulting walk reports `raddr` 0 with both permissions clear. A page-level result is entry bits 63:12 joined with the byte offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 64 | Virtual address to translate |
| space_desc | input | 64 | Space descriptor: origin, private, real, type, length |
| seg_frame_en | input | 1 | Enables segment large frames and region protection |
| rgn_frame_en | input | 1 | Enables region-third large frames and common-region check |
| xprot_en | input | 1 | Enables execute protection |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 4 | 0 success, else exception code |
| raddr | output | 64 | Translated real address |
| wr_ok | output | 1 | Write permitted |
| ex_ok | output | 1 | Execute permitted |
| mem_req_valid | output | 1 | Table entry read request (one cycle) |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Entry bytes, lane k = address+k |
| mem_rsp_err | input | 1 | Read failed |

## Verification
The bench counts memory reads on every walk. A design that reads before the start checks, or that reads through the real-space case, therefore shows up at once. It walks full four-level chains and starts mid-chain, so a wrong origin/index sum or a missing byte swap sends the walker to an empty slot, which reads as an invalid-page fault. It flips each enable around the large-frame, protection and common bits: a design that ignores an enable either stops early with a frame-based address or keeps walking past a large frame. It probes both bounds of the next-index range and an erroring read, and a design with an off-by-one level mapping reports the wrong exception code.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int OFF_W    = 12;
  localparam int PX_W     = 8;
  localparam int IX_W     = 11;
  localparam int N_RGN    = 4;
  localparam int SX_LO    = OFF_W + PX_W;
  localparam int R3_LO    = SX_LO + IX_W;
  localparam int VA_W     = SX_LO + N_RGN * IX_W;
  localparam int ENT_W    = 64;
  localparam int ENT_B    = ENT_W / 8;
  localparam int PT_ALIGN = PX_W + 3;

  // entry bit positions
  localparam int B_COM  = 4;
  localparam int B_INV  = 5;
  localparam int B_XP   = 8;
  localparam int B_PROT = 9;
  localparam int B_FC   = 10;
  localparam int B_RSV  = 11;

  // descriptor bit positions
  localparam int D_REAL = 4;
  localparam int D_PRIV = 5;

  typedef enum logic [2:0] {
    LV_SEG = 3'd0, LV_R3 = 3'd1, LV_R2 = 3'd2, LV_R1 = 3'd3, LV_PG = 3'd4
  } lvl_e;

  typedef enum logic [3:0] {
    XC_NONE = 4'd0, XC_ADDR = 4'd1, XC_SPEC = 4'd2, XC_ATYPE = 4'd3,
    XC_R1 = 4'd4, XC_R2 = 4'd5, XC_R3 = 4'd6, XC_SEG = 4'd7, XC_PAGE = 4'd8
  } xcode_e;

  function automatic xcode_e lvl_xc(input lvl_e l);
    case (l)
      LV_R1:   return XC_R1;
      LV_R2:   return XC_R2;
      LV_R3:   return XC_R3;
      LV_SEG:  return XC_SEG;
      default: return XC_PAGE;
    endcase
  endfunction
endpackage

// File: rtl/ptw_va_split.sv
`timescale 1ns/1ps
module ptw_va_split import ptw_pkg::*; (
  input  logic [VA_W-OFF_W-1:0]       va_pg,
  input  logic [1:0]                  first_lvl,
  output logic [N_RGN-1:0][IX_W-1:0]  ix,
  output logic [PX_W-1:0]             px,
  output logic                        hi_nz
);
  for (genvar k = 0; k < N_RGN; k++) begin : g_ix
    assign ix[k] = va_pg[PX_W + k*IX_W +: IX_W];
  end
  assign px = va_pg[PX_W-1:0];

  always_comb begin
    hi_nz = 1'b0;
    for (int k = 0; k < N_RGN; k++) begin
      if (k > int'(first_lvl) && ix[k] != '0) hi_nz = 1'b1;
    end
  end
endmodule

// File: rtl/ptw_entry_eval.sv
`timescale 1ns/1ps
module ptw_entry_eval import ptw_pkg::*; (
  input  lvl_e                        lvl,
  input  logic [ENT_W-1:0]            raw,
  input  logic [N_RGN-1:0][IX_W-1:0]  ix,
  input  logic [PX_W-1:0]             px,
  input  logic [R3_LO-1:0]            va_lo,
  input  logic                        e1,
  input  logic                        e2_raw,
  input  logic                        xp_en,
  input  logic                        priv,
  output xcode_e                      xc,
  output logic                        leaf,
  output logic                        clr_wr,
  output logic                        clr_ex,
  output logic [VA_W-1:0]             nxt_addr,
  output logic [VA_W-1:0]             leaf_addr
);
  logic [ENT_W-1:0] ent;
  logic             e2;
  logic [1:0]       down;
  logic [IX_W-1:0]  nix;
  logic [1:0]       ntop;

  // big-endian: lane k carries byte address+k, the most significant first
  for (genvar b = 0; b < ENT_B; b++) begin : g_swap
    assign ent[8*b +: 8] = raw[8*(ENT_B-1-b) +: 8];
  end

  assign e2   = e1 & e2_raw;
  assign down = lvl[1:0] - 2'd1;
  assign nix  = ix[down];
  assign ntop = nix[IX_W-1 -: 2];

  always_comb begin
    xc        = XC_NONE;
    leaf      = 1'b0;
    clr_wr    = 1'b0;
    clr_ex    = 1'b0;
    nxt_addr  = '0;
    leaf_addr = '0;
    case (lvl)
      LV_PG: begin
        if (ent[B_INV])      xc = XC_PAGE;
        else if (ent[B_RSV]) xc = XC_SPEC;
        else begin
          leaf      = 1'b1;
          clr_wr    = ent[B_PROT];
          clr_ex    = xp_en & ent[B_XP];
          leaf_addr = {ent[VA_W-1:OFF_W], va_lo[OFF_W-1:0]};
        end
      end
      LV_SEG: begin
        if (ent[B_INV])                 xc = XC_SEG;
        else if (ent[3:2] != 2'd0)      xc = XC_SPEC;
        else if (ent[B_COM] && priv)    xc = XC_SPEC;
        else begin
          clr_wr = ent[B_PROT];
          if (e1 && ent[B_FC]) begin
            leaf      = 1'b1;
            clr_ex    = xp_en & ent[B_XP];
            leaf_addr = {ent[VA_W-1:SX_LO], va_lo[SX_LO-1:0]};
          end else begin
            nxt_addr = {ent[VA_W-1:PT_ALIGN], {PT_ALIGN{1'b0}}} + (VA_W'(px) << 3);
          end
        end
      end
      default: begin
        if (ent[B_INV])                                      xc = lvl_xc(lvl);
        else if (ent[3:2] != lvl[1:0])                       xc = XC_SPEC;
        else if (lvl == LV_R3 && e2 && ent[B_COM] && priv)   xc = XC_SPEC;
        else begin
          clr_wr = e1 & ent[B_PROT];
          if (lvl == LV_R3 && e2 && ent[B_FC]) begin
            leaf      = 1'b1;
            clr_ex    = xp_en & ent[B_XP];
            leaf_addr = {ent[VA_W-1:R3_LO], va_lo};
          end else if (ntop < ent[7:6] || ntop > ent[1:0]) begin
            xc = lvl_xc(lvl_e'({1'b0, down}));
          end else begin
            nxt_addr = {ent[VA_W-1:OFF_W], {OFF_W{1'b0}}} + (VA_W'(nix) << 3);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker import ptw_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      vaddr,
  input  logic [63:0]      space_desc,
  input  logic             seg_frame_en,
  input  logic             rgn_frame_en,
  input  logic             xprot_en,
  output logic             busy,
  output logic             done,
  output logic [3:0]       fault_code,
  output logic [63:0]      raddr,
  output logic             wr_ok,
  output logic             ex_ok,
  output logic             mem_req_valid,
  output logic [63:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  input  logic             mem_rsp_err
);
  typedef enum logic [1:0] {S_IDLE, S_BEGIN, S_REQ, S_WAIT} st_e;

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic unused_desc;
  assign unused_desc = ^space_desc[OFF_W-1:D_PRIV+1];

  // captured request
  logic [VA_W-1:0]   va_q;
  logic [VA_W-1:OFF_W] org_q;
  logic              priv_q, real_q, e1_q, e2_q, xp_q;
  logic [1:0]        typ_q, tl_q;
  // walk state
  st_e               st, st_d;
  lvl_e              lvl_q, lvl_d;
  logic [VA_W-1:0]   addr_q, addr_d, ra_q, ra_d;
  logic              wr_q, wr_d, ex_q, ex_d, done_q, done_d, lat_en;
  xcode_e            xc_q, xc_d;

  logic [N_RGN-1:0][IX_W-1:0] ix;
  logic [PX_W-1:0]   px;
  logic              hi_nz;
  logic [IX_W-1:0]   first_ix;
  xcode_e            ev_xc;
  logic              ev_leaf, ev_clr_wr, ev_clr_ex;
  logic [VA_W-1:0]   ev_nxt, ev_leaf_addr;
  logic              flt;
  xcode_e            flt_code;

  ptw_va_split u_split (
    .va_pg     (va_q[VA_W-1:OFF_W]),
    .first_lvl (typ_q),
    .ix        (ix),
    .px        (px),
    .hi_nz     (hi_nz)
  );

  ptw_entry_eval u_eval (
    .lvl       (lvl_q),
    .raw       (mem_rsp_data),
    .ix        (ix),
    .px        (px),
    .va_lo     (va_q[R3_LO-1:0]),
    .e1        (e1_q),
    .e2_raw    (e2_q),
    .xp_en     (xp_q),
    .priv      (priv_q),
    .xc        (ev_xc),
    .leaf      (ev_leaf),
    .clr_wr    (ev_clr_wr),
    .clr_ex    (ev_clr_ex),
    .nxt_addr  (ev_nxt),
    .leaf_addr (ev_leaf_addr)
  );

  assign first_ix = ix[typ_q];

  always_comb begin
    st_d     = st;
    lvl_d    = lvl_q;
    addr_d   = addr_q;
    wr_d     = wr_q;
    ex_d     = ex_q;
    ra_d     = ra_q;
    xc_d     = xc_q;
    done_d   = 1'b0;
    lat_en   = 1'b0;
    flt      = 1'b0;
    flt_code = XC_NONE;
    unique case (st)
      S_IDLE: if (start) begin
        lat_en = 1'b1;
        wr_d   = 1'b1;
        ex_d   = 1'b1;
        st_d   = S_BEGIN;
      end
      S_BEGIN: begin
        if (real_q) begin
          ra_d   = va_q;
          xc_d   = XC_NONE;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if (hi_nz) begin
          flt = 1'b1; flt_code = XC_ATYPE;
        end else if (first_ix[IX_W-1 -: 2] > tl_q) begin
          flt = 1'b1; flt_code = lvl_xc(lvl_e'({1'b0, typ_q}));
        end else begin
          lvl_d  = lvl_e'({1'b0, typ_q});
          addr_d = {org_q, {OFF_W{1'b0}}} + (VA_W'(first_ix) << 3);
          st_d   = S_REQ;
        end
      end
      S_REQ: st_d = S_WAIT;
      S_WAIT: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          flt = 1'b1; flt_code = XC_ADDR;
        end else if (ev_xc != XC_NONE) begin
          flt = 1'b1; flt_code = ev_xc;
        end else begin
          wr_d = wr_q & ~ev_clr_wr;
          ex_d = ex_q & ~ev_clr_ex;
          if (ev_leaf) begin
            ra_d   = ev_leaf_addr;
            xc_d   = XC_NONE;
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            addr_d = ev_nxt;
            lvl_d  = (lvl_q == LV_SEG) ? LV_PG : lvl_e'(lvl_q - 3'd1);
            st_d   = S_REQ;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (flt) begin
      xc_d   = flt_code;
      ra_d   = '0;
      wr_d   = 1'b0;
      ex_d   = 1'b0;
      done_d = 1'b1;
      st_d   = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      va_q   <= '0;
      org_q  <= '0;
      priv_q <= 1'b0;
      real_q <= 1'b0;
      typ_q  <= 2'd0;
      tl_q   <= 2'd0;
      e1_q   <= 1'b0;
      e2_q   <= 1'b0;
      xp_q   <= 1'b0;
    end else if (lat_en) begin
      va_q   <= vaddr;
      org_q  <= space_desc[VA_W-1:OFF_W];
      priv_q <= space_desc[D_PRIV];
      real_q <= space_desc[D_REAL];
      typ_q  <= space_desc[3:2];
      tl_q   <= space_desc[1:0];
      e1_q   <= seg_frame_en;
      e2_q   <= rgn_frame_en;
      xp_q   <= xprot_en;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st     <= S_IDLE;
      lvl_q  <= LV_SEG;
      addr_q <= '0;
      ra_q   <= '0;
      wr_q   <= 1'b0;
      ex_q   <= 1'b0;
      xc_q   <= XC_NONE;
      done_q <= 1'b0;
    end else begin
      st     <= st_d;
      lvl_q  <= lvl_d;
      addr_q <= addr_d;
      ra_q   <= ra_d;
      wr_q   <= wr_d;
      ex_q   <= ex_d;
      xc_q   <= xc_d;
      done_q <= done_d;
    end
  end

  assign busy          = (st != S_IDLE);
  assign done          = done_q;
  assign fault_code    = xc_q;
  assign raddr         = ra_q;
  assign wr_ok         = wr_q;
  assign ex_ok         = ex_q;
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = addr_q;

  // R4: requests are single-cycle and 8-byte aligned
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_s)
    mem_req_valid |=> !mem_req_valid);
  p_req_align_r4: assert property (@(posedge clk) disable iff (!rst_s)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));
  // R13: done is a pulse; faults carry no permission
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  p_fault_noperm_r13: assert property (@(posedge clk) disable iff (!rst_s)
    (done && fault_code != 4'd0) |-> (!wr_ok && !ex_ok && raddr == '0));
  p_busy_start_r13: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> $past(start));
  // R1: real space finishes at once with the input address
  p_real_result_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (st == S_BEGIN && real_q) |=> (done && !mem_req_valid && raddr == $past(va_q)));
  // R12: failed read gives addressing code
  p_err_addr_r12: assert property (@(posedge clk) disable iff (!rst_s)
    (st == S_WAIT && mem_rsp_valid && mem_rsp_err) |=> (done && fault_code == 4'd1));
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] vaddr = '0, space_desc = '0;
  logic        seg_frame_en = 1'b0, rgn_frame_en = 1'b0, xprot_en = 1'b0;
  logic        busy, done, wr_ok, ex_ok, mem_req_valid;
  logic [3:0]  fault_code;
  logic [63:0] raddr, mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .space_desc(space_desc),
    .seg_frame_en(seg_frame_en), .rgn_frame_en(rgn_frame_en), .xprot_en(xprot_en),
    .busy(busy), .done(done), .fault_code(fault_code), .raddr(raddr),
    .wr_ok(wr_ok), .ex_ok(ex_ok), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
  );

  localparam logic [63:0] F_COM = 64'h10, F_INV = 64'h20, F_XP = 64'h100,
                          F_PROT = 64'h200, F_FC = 64'h400, F_RSV = 64'h800;

  typedef struct {
    logic [3:0]  xc;
    logic [63:0] ra;
    logic        wr, ex;
    int          rd, base;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [63:0] mem [logic [63:0]];
  int          nreads = 0, checks = 0, fails = 0;
  logic        pend = 1'b0, prev_done = 1'b0;
  logic [63:0] paddr = '0;

  function automatic logic [63:0] swap(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] rgn(input logic [63:0] org, input logic [1:0] tt,
                                      input logic [1:0] tf, input logic [1:0] tl,
                                      input logic [63:0] fl);
    return {org[63:12], 4'b0, tf, 2'b0, tt, tl} | fl;
  endfunction

  function automatic logic [63:0] desc(input logic [63:0] org, input logic priv,
                                       input logic rl, input logic [1:0] typ,
                                       input logic [1:0] tl);
    return {org[63:12], 6'b0, priv, rl, typ, tl};
  endfunction

  // memory model: answers two negedges after a request
  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= swap(mem.exists(paddr) ? mem[paddr] : 64'h0);
      mem_rsp_err   <= (paddr[63:60] == 4'hF);
      pend          <= 1'b0;
    end else if (mem_req_valid) begin
      pend   <= 1'b1;
      paddr  <= mem_req_addr;
      nreads <= nreads + 1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) begin
        fails++; $display("FAIL R13 done held two cycles: got 1 expected 0");
      end
      if (done) begin
        if (expq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R13 unexpected done: got 1 expected 0");
        end else begin
          exp_t e;
          e = expq.pop_front();
          checks++;
          if (fault_code !== e.xc) begin
            fails++; $display("FAIL %s code: got %0d expected %0d", e.tag, fault_code, e.xc);
          end
          checks++;
          if (raddr !== e.ra) begin
            fails++; $display("FAIL %s raddr: got %h expected %h", e.tag, raddr, e.ra);
          end
          checks++;
          if ({wr_ok, ex_ok} !== {e.wr, e.ex}) begin
            fails++; $display("FAIL %s wr/ex: got %b%b expected %b%b", e.tag, wr_ok, ex_ok, e.wr, e.ex);
          end
          checks++;
          if (nreads - e.base != e.rd) begin
            fails++; $display("FAIL %s reads: got %0d expected %0d", e.tag, nreads - e.base, e.rd);
          end
        end
      end
    end
    prev_done <= done;
  end

  task automatic run(input logic [63:0] va, input logic [63:0] d, input logic e1,
                     input logic e2, input logic xp, input logic [3:0] xc,
                     input logic [63:0] ra, input logic wr, input logic ex,
                     input int rd, input string tag);
    exp_t e;
    e.xc = xc; e.ra = ra; e.wr = wr; e.ex = ex; e.rd = rd; e.base = nreads; e.tag = tag;
    expq.push_back(e);
    vaddr = va; space_desc = d; seg_frame_en = e1; rgn_frame_en = e2; xprot_en = xp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // baseline chain: R1 idx 1, R2 idx 2, R3 idx 3, seg idx 4, page idx 5
  task automatic build();
    mem.delete();
    mem[64'h10008] = rgn(64'h20000, 2'd3, 2'd0, 2'd3, 64'h0);
    mem[64'h20010] = rgn(64'h30000, 2'd2, 2'd0, 2'd3, 64'h0);
    mem[64'h30018] = rgn(64'h40000, 2'd1, 2'd0, 2'd3, 64'h0);
    mem[64'h40020] = 64'h50800;
    mem[64'h50828] = 64'hABCDE000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] va0, va1, vs, d1, ds;
    va0 = (64'd1 << 53) | (64'd2 << 42) | (64'd3 << 31) | (64'd4 << 20) | (64'd5 << 12) | 64'h123;
    va1 = (va0 & ~(64'h7FF << 31)) | (64'h203 << 31);
    vs  = (64'd4 << 20) | (64'd5 << 12) | 64'h456;
    d1  = desc(64'h10000, 1'b0, 1'b0, 2'd3, 2'd3);
    ds  = desc(64'h40000, 1'b0, 1'b0, 2'd0, 2'd3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({busy, done, mem_req_valid} !== 3'b000) begin
      fails++; $display("FAIL R13 reset state: got %b expected 000", {busy, done, mem_req_valid});
    end

    build();
    run(va0, d1, 0, 0, 0, 4'd0, 64'hABCDE123, 1, 1, 5, "R4 R13 full walk");
    run(va0, d1 | 64'h10, 0, 0, 0, 4'd0, va0, 1, 1, 0, "R1 real space");
    run(vs, ds, 0, 0, 0, 4'd0, 64'hABCDE456, 1, 1, 2, "R2 segment start");
    run(vs | (64'd1 << 31), ds, 0, 0, 0, 4'd3, 0, 0, 0, 0, "R2 higher index set");
    run((64'h201 << 53), desc(64'h10000, 0, 0, 2'd3, 2'd0), 0, 0, 0, 4'd4, 0, 0, 0, 0, "R3 first length");
    run((64'h201 << 42), desc(64'h20000, 0, 0, 2'd2, 2'd0), 0, 0, 0, 4'd5, 0, 0, 0, 0, "R3 second start length");

    build(); mem[64'h20010] |= F_INV;
    run(va0, d1, 0, 0, 0, 4'd5, 0, 0, 0, 2, "R5 invalid region-second");
    build(); mem[64'h40020] |= F_INV;
    run(va0, d1, 0, 0, 0, 4'd7, 0, 0, 0, 4, "R5 invalid segment");
    build(); mem[64'h50828] |= F_INV;
    run(va0, d1, 0, 0, 0, 4'd8, 0, 0, 0, 5, "R5 invalid page");

    build(); mem[64'h30018] = rgn(64'h40000, 2'd2, 2'd0, 2'd3, 64'h0);
    run(va0, d1, 0, 0, 0, 4'd2, 0, 0, 0, 3, "R6 type mismatch");

    build(); mem[64'h10008] = rgn(64'h20000, 2'd3, 2'd1, 2'd3, 64'h0);
    run(va0, d1, 0, 0, 0, 4'd5, 0, 0, 0, 1, "R7 below offset");
    build(); mem[64'h20010] = rgn(64'h30000, 2'd2, 2'd0, 2'd0, 64'h0);
    run(va1, d1, 0, 0, 0, 4'd6, 0, 0, 0, 2, "R7 above length");

    build(); mem[64'h20010] |= F_PROT;
    run(va0, d1, 0, 0, 0, 4'd0, 64'hABCDE123, 1, 1, 5, "R8 region protect ignored");
    run(va0, d1, 1, 0, 0, 4'd0, 64'hABCDE123, 0, 1, 5, "R8 region protect");
    build(); mem[64'h50828] |= F_PROT;
    run(va0, d1, 0, 0, 0, 4'd0, 64'hABCDE123, 0, 1, 5, "R8 page protect");

    build(); mem[64'h40020] = 64'h12300000 | F_FC;
    run(va0, d1, 1, 0, 0, 4'd0, 64'h12305123, 1, 1, 4, "R9 segment frame");
    build(); mem[64'h40020] = 64'h50800 | F_FC;
    run(va0, d1, 0, 0, 0, 4'd0, 64'hABCDE123, 1, 1, 5, "R9 segment frame ignored");
    build(); mem[64'h30018] = rgn(64'h80000000, 2'd1, 2'd0, 2'd0, F_FC);
    run(va0, d1, 1, 1, 0, 4'd0, 64'h80405123, 1, 1, 3, "R9 region-third frame");
    build(); mem[64'h30018] |= F_FC;
    run(va0, d1, 1, 0, 0, 4'd0, 64'hABCDE123, 1, 1, 5, "R9 region frame ignored");

    build(); mem[64'h40020] |= F_COM;
    run(va0, d1 | 64'h20, 0, 0, 0, 4'd2, 0, 0, 0, 4, "R10 common segment private");
    run(va0, d1, 0, 0, 0, 4'd0, 64'hABCDE123, 1, 1, 5, "R10 common segment shared");
    build(); mem[64'h30018] |= F_COM;
    run(va0, d1 | 64'h20, 1, 1, 0, 4'd2, 0, 0, 0, 3, "R10 common region private");
    run(va0, d1 | 64'h20, 1, 0, 0, 4'd0, 64'hABCDE123, 1, 1, 5, "R10 common region no enable");
    build(); mem[64'h50828] |= F_RSV;
    run(va0, d1, 0, 0, 0, 4'd2, 0, 0, 0, 5, "R10 page reserved");

    build(); mem[64'h50828] |= F_XP;
    run(va0, d1, 0, 0, 1, 4'd0, 64'hABCDE123, 1, 0, 5, "R11 page exec protect");
    run(va0, d1, 0, 0, 0, 4'd0, 64'hABCDE123, 1, 1, 5, "R11 exec protect off");
    build(); mem[64'h40020] = 64'h12300000 | F_FC | F_XP;
    run(va0, d1, 1, 0, 1, 4'd0, 64'h12305123, 1, 0, 4, "R11 frame exec protect");

    build(); mem[64'h40020] = 64'hF000_0000_0000_0800;
    run(va0, d1, 0, 0, 0, 4'd1, 0, 0, 0, 5, "R12 read error");

    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++; $display("FAIL R13 pending results: got %0d expected 0", expq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule